// File: doc/BRIEF.md
# Programmable Interval Timer with Delayed Reload

This block keeps a free-running 8-bit divider and a programmable 8-bit counter. Both advance on a system clock-cycle tick strobe. The divider steps once every fixed number of ticks. The counter steps at one of four selectable rates, and only while it is enabled. A CPU reads and writes four byte registers (divider, counter, modulo and control) through a simple select, write-strobe and data interface.

When the counter steps past its top value, it does not reload at once. It first reads zero for a short reload delay. At the end of that delay it takes the modulo value and sends a single-cycle interrupt request to the interrupt controller. A CPU write to the counter during the delay cancels both the reload and the interrupt. A CPU write to the divider clears the sub-step prescalers of the divider and the counter, so software can restart the timing phase.

Top module: `prog_timer`

## Requirements
- R1: With no divider write, the divider (select 00) increments once every DIV_INTERVAL ticks (default 256) and wraps modulo 256.
- R2: A write to select 00 loads the written byte into the divider and clears both the divider prescaler and the counter prescaler. After the write, the next divider step comes exactly DIV_INTERVAL ticks later.
- R3: Control bits 1:0 select the counter period in ticks: code 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256.
- R4: While control bit 2 (enable) is 0 and no reload is pending, the counter (select 01) holds its value and its prescaler does not advance.
- R5: A step from 0xFF sets the counter to 0x00 and starts a reload delay of RELOAD_DELAY ticks (default 4). The counter reads 0x00 during the delay and does not step.
- R6: On the last tick of the reload delay, the counter loads the modulo value and `irq` is high for exactly one clock cycle. At no other time is `irq` high.
- R7: The reload delay keeps counting down and ends in a reload and `irq` even if the enable bit is cleared while the delay is running.
- R8: A write to select 01 while a reload is pending (including on its final tick) loads the written byte, cancels the reload and suppresses that `irq`. A counter write also overrides any step in the same cycle.
- R9: The modulo register (select 10) reads back the last byte written. A reload in the same cycle as a modulo write uses the value held before that write.
- R10: The control register (select 11) reads back as {5'b11111, enable, rate[1:0]}.
- R11: After reset the divider, counter, modulo and control fields are zero, control reads 0xF8, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One system clock-cycle tick strobe |
| sel | input | 2 | Register select: 00 divider, 01 counter, 10 modulo, 11 control |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Single-cycle timer interrupt request |

## Verification
The assertions assume at least one tick between an overflow and its reload, which means RELOAD_DELAY is at least 1. They also assume every counter period is longer than the reload delay, so a second overflow can never follow an `irq` in the next cycle. The stimulus keeps to the default parameters, whose shortest period of 16 ticks is far longer than the 4-tick delay. It writes registers only through the select and strobe interface, and it biases counter writes toward values near 0xFF so that overflows, delays and cancellations happen often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SEL_DIV = 2'd0,
        SEL_CNT = 2'd1,
        SEL_MOD = 2'd2,
        SEL_CTL = 2'd3
    } tmr_sel_e;

    localparam int CTL_EN_BIT = 2;
endpackage

// File: rtl/tmr_div_unit.sv
module tmr_div_unit #(
    parameter int DIV_INTERVAL = 256,
    parameter int W            = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);
    localparam int PW = (DIV_INTERVAL > 1) ? $clog2(DIV_INTERVAL) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV_INTERVAL - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [W-1:0]  val;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.pre = '0;
            s_d.val = wr_data;
        end else if (tick) begin
            if (s_q.pre == LAST) begin
                s_d.pre = '0;
                s_d.val = s_q.val + 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.val;

    AST_DIV_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (s_q.pre == '0)); // R2
    AST_DIV_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && s_q.pre != LAST) |=> $stable(s_q.val)); // R1
endmodule

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
    parameter int W            = 8,
    parameter int PERIOD0      = 1024,
    parameter int PERIOD1      = 16,
    parameter int PERIOD2      = 64,
    parameter int PERIOD3      = 256,
    parameter int RELOAD_DELAY = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic [1:0]   rate,
    input  logic         pre_clr,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         irq
);
    localparam int MAX01 = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
    localparam int MAX23 = (PERIOD2 > PERIOD3) ? PERIOD2 : PERIOD3;
    localparam int MAXP  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int PW    = (MAXP > 1) ? $clog2(MAXP) : 1;
    localparam int DW    = $clog2(RELOAD_DELAY + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [W-1:0]  val;
        logic          pend;
        logic [DW-1:0] pcnt;
        logic          irq;
    } cnt_st_t;

    cnt_st_t     s_d, s_q;
    logic [31:0] period_m1;
    logic        step;

    always_comb begin
        case (rate)
            2'd0:    period_m1 = 32'(PERIOD0 - 1);
            2'd1:    period_m1 = 32'(PERIOD1 - 1);
            2'd2:    period_m1 = 32'(PERIOD2 - 1);
            default: period_m1 = 32'(PERIOD3 - 1);
        endcase
    end

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        step    = 1'b0;
        if (pre_clr) begin
            s_d.pre = '0;
        end else if (tick && en) begin
            if (32'(s_q.pre) >= period_m1) begin
                s_d.pre = '0;
                step    = 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
        if (tick && s_q.pend) begin
            if (s_q.pcnt == DW'(1)) begin
                s_d.val  = reload_val;
                s_d.pend = 1'b0;
                s_d.pcnt = '0;
                s_d.irq  = 1'b1;
            end else begin
                s_d.pcnt = s_q.pcnt - 1'b1;
            end
        end else if (step && !s_q.pend) begin
            if (s_q.val == '1) begin
                s_d.val  = '0;
                s_d.pend = 1'b1;
                s_d.pcnt = DW'(RELOAD_DELAY);
            end else begin
                s_d.val = s_q.val + 1'b1;
            end
        end
        if (wr) begin
            s_d.val  = wr_data;
            s_d.pend = 1'b0;
            s_d.pcnt = '0;
            s_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.val;
    assign irq   = s_q.irq;

    AST_PEND_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |-> (s_q.val == '0)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_LOADS_MODULO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.val == $past(reload_val))); // R6
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !s_q.pend && !wr) |=> $stable(s_q.val)); // R4
    AST_WR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!s_q.pend && !irq)); // R8
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int DIV_INTERVAL = 256,
    parameter int PERIOD0      = 1024,
    parameter int PERIOD1      = 16,
    parameter int PERIOD2      = 64,
    parameter int PERIOD3      = 256,
    parameter int RELOAD_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    import tmr_pkg::*;

    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] modulo;
        logic [2:0]   ctl;
    } cfg_st_t;

    cfg_st_t      c_d, c_q;
    tmr_sel_e     sel_e;
    logic         div_wr, cnt_wr;
    logic [W-1:0] div_val, cnt_val;

    assign sel_e  = tmr_sel_e'(sel);
    assign div_wr = wr_en && (sel_e == SEL_DIV);
    assign cnt_wr = wr_en && (sel_e == SEL_CNT);

    always_comb begin
        c_d = c_q;
        if (wr_en && sel_e == SEL_MOD) c_d.modulo = wr_data;
        if (wr_en && sel_e == SEL_CTL) c_d.ctl    = wr_data[2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    tmr_div_unit #(.DIV_INTERVAL(DIV_INTERVAL), .W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr      (div_wr),
        .wr_data (wr_data),
        .value   (div_val)
    );

    tmr_cnt_unit #(
        .W(W), .PERIOD0(PERIOD0), .PERIOD1(PERIOD1), .PERIOD2(PERIOD2),
        .PERIOD3(PERIOD3), .RELOAD_DELAY(RELOAD_DELAY)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .en         (c_q.ctl[CTL_EN_BIT]),
        .rate       (c_q.ctl[1:0]),
        .pre_clr    (div_wr),
        .wr         (cnt_wr),
        .wr_data    (wr_data),
        .reload_val (c_q.modulo),
        .value      (cnt_val),
        .irq        (irq)
    );

    always_comb begin
        case (sel_e)
            SEL_DIV: rd_data = div_val;
            SEL_CNT: rd_data = cnt_val;
            SEL_MOD: rd_data = c_q.modulo;
            default: rd_data = {5'b11111, c_q.ctl};
        endcase
    end

    AST_MOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_e == SEL_MOD) |=> $stable(c_q.modulo)); // R9
    AST_CTL_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_e == SEL_CTL) |-> (rd_data[7:3] == 5'b11111)); // R10
endmodule

// File: tb/prog_timer_bench.sv
module prog_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state, driven only by the requirement rules
    logic [7:0] m_div, m_cnt, m_mod;
    logic [2:0] m_ctl;
    int         m_dpre, m_cpre, m_pcnt;
    bit         m_pend, m_irq;

    always #10 clk = ~clk;

    prog_timer u_prog_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic int period_of(input logic [1:0] r);
        case (r)
            2'd0: return 1024;   // R3
            2'd1: return 16;
            2'd2: return 64;
            default: return 256;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: return m_div;
            2'd1: return m_cnt;
            2'd2: return m_mod;
            default: return {5'b11111, m_ctl};   // R10
        endcase
    endfunction

    task automatic model_reset();
        m_div = 0; m_cnt = 0; m_mod = 0; m_ctl = 0;
        m_dpre = 0; m_cpre = 0; m_pcnt = 0; m_pend = 0; m_irq = 0;
    endtask

    task automatic model_step(input bit t, input logic [1:0] s, input bit w, input logic [7:0] d);
        bit step = 0;
        // R1 / R2 divider
        if (w && s == 2'd0) begin m_div = d; m_dpre = 0; end
        else if (t) begin
            if (m_dpre == 255) begin m_dpre = 0; m_div = m_div + 8'd1; end
            else m_dpre++;
        end
        // R3 / R4 prescaler
        m_irq = 0;
        if (w && s == 2'd0) m_cpre = 0;
        else if (t && m_ctl[2]) begin
            if (m_cpre >= period_of(m_ctl[1:0]) - 1) begin m_cpre = 0; step = 1; end
            else m_cpre++;
        end
        // R5 / R6 / R7 overflow and delayed reload
        if (t && m_pend) begin
            if (m_pcnt == 1) begin m_cnt = m_mod; m_pend = 0; m_pcnt = 0; m_irq = 1; end
            else m_pcnt--;
        end else if (step) begin
            if (m_cnt == 8'hFF) begin m_cnt = 0; m_pend = 1; m_pcnt = 4; end
            else m_cnt = m_cnt + 8'd1;
        end
        // R8 counter write
        if (w && s == 2'd1) begin m_cnt = d; m_pend = 0; m_pcnt = 0; m_irq = 0; end
        // R9 / R10 configuration, old values used above
        if (w && s == 2'd2) m_mod = d;
        if (w && s == 2'd3) m_ctl = d[2:0];
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'd0: return "R1";
            2'd1: return "R5";
            2'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    // one clock: drive at the falling edge, model at the rising edge, sample at the next falling edge
    task automatic cycle(input bit t, input logic [1:0] s, input bit w, input logic [7:0] d);
        tick = t; sel = s; wr_en = w; wr_data = d;
        @(posedge clk);
        model_step(t, s, w, d);
        @(negedge clk);
        check("R6", {7'd0, irq}, {7'd0, m_irq});
        check(tag_of(s), rd_data, exp_read(s));
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        cycle(1'b1, s, 1'b1, d);
    endtask

    task automatic peek(input string tag, input logic [1:0] s);
        cycle(1'b0, s, 1'b0, 8'd0);
        check(tag, rd_data, exp_read(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11", rd_data, 8'h00);
        peek("R11", 2'd3);
        check("R11", rd_data, 8'hF8);
        check("R11", {7'd0, irq}, 8'h00);

        // R2 divider write restarts phase
        repeat (100) cycle(1'b1, 2'd0, 1'b0, 8'd0);
        wr(2'd0, 8'h10);
        repeat (255) cycle(1'b1, 2'd0, 1'b0, 8'd0);
        check("R2", rd_data, 8'h10);
        cycle(1'b1, 2'd0, 1'b0, 8'd0);
        check("R2", rd_data, 8'h11);

        // R4 disabled counter holds
        wr(2'd1, 8'h42);
        repeat (300) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R4", rd_data, 8'h42);

        // R3 each rate
        for (int r = 0; r < 4; r++) begin
            wr(2'd3, 8'h04 | 8'(r));
            wr(2'd0, 8'h00);
            wr(2'd1, 8'h00);
            repeat (period_of(2'(r)) * 3) cycle(1'b1, 2'd1, 1'b0, 8'd0);
            check("R3", rd_data, m_cnt);
            check("R3", rd_data, 8'd3);
        end

        // R5 / R6 overflow, zero during delay, reload
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h05);
        wr(2'd1, 8'hFF);
        while (!m_pend) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R5", rd_data, 8'h00);
        repeat (3) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R5", rd_data, 8'h00);
        cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R6", {7'd0, irq}, 8'h01);
        check("R6", rd_data, 8'hA5);
        cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R6", {7'd0, irq}, 8'h00);

        // R7 delay continues with enable cleared
        wr(2'd1, 8'hFF);
        while (!m_pend) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        wr(2'd3, 8'h01);
        while (m_pend) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        check("R7", {7'd0, irq}, 8'h01);
        check("R7", rd_data, 8'hA5);

        // R8 counter write cancels pending reload
        wr(2'd3, 8'h05);
        wr(2'd1, 8'hFF);
        while (!m_pend) cycle(1'b1, 2'd1, 1'b0, 8'd0);
        wr(2'd1, 8'h33);
        snap = 8'h00;
        repeat (6) begin
            cycle(1'b1, 2'd1, 1'b0, 8'd0);
            snap = snap | {7'd0, irq};
        end
        check("R8", snap, 8'h00);
        check("R8", rd_data, 8'h33);

        // R9 modulo read back
        wr(2'd2, 8'h5A);
        peek("R9", 2'd2);
        check("R9", rd_data, 8'h5A);

        // constrained random mix
        for (int i = 0; i < 20000; i++) begin
            bit         t = ($urandom % 8) != 0;
            logic [1:0] s = 2'($urandom % 4);
            bit         w = ($urandom % 24) == 0;
            logic [7:0] d = 8'($urandom);
            if (w && s == 2'd1) d = 8'hF0 | d[3:0];
            if (w && s == 2'd3) d[2:0] = 3'b101 | {1'b0, d[1], 1'b0};
            cycle(t, s, w, d);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule